// File: doc/BRIEF.md
# Dual-Bank Programmable Clock Divider

The block takes a single input clock and produces two output banks from it. The first bank passes the input clock through at full rate, behind a glitch-free gate. The second bank carries a lower-rate copy of the input clock, divided by 2, 4, 8 or 16 according to a two-bit select input. That lower-rate copy is fanned out to identical outputs, two by default.

One active-low control serves both banks, but it acts on each bank differently. On the divided bank it clears the divider at once, with no clock edge needed. On the pass-through bank it is sampled on the falling edge of the input clock, so the gate only opens or closes while the clock is low. No output pulse is ever cut short. All divided-output transitions happen on input rising edges, so the divided bank stays in phase with the pass-through bank at every ratio.

The block is intended for a clock tree that needs both the full-rate clock and a set of auxiliary slower clocks that are frequency-locked to it. The active-low control resets the divided clocks to a known phase.

Top module: `clkdiv_dual_bank`

## Requirements
- R1: With `div_sel` held steady, the divided outputs have a period of 2, 4, 8 or 16 input periods for `div_sel` = 2'b00, 2'b01, 2'b10, 2'b11 respectively, with the output high for exactly half of that period.
- R2: Every bit of `bank_b_out` carries the same value at all times.
- R3: While `rst_n` is low, all `bank_b_out` bits are low, and they go low as soon as `rst_n` falls, without waiting for a clock edge.
- R4: After `rst_n` rises, the divided outputs stay low until the first input rising edge, and that edge drives them high for every ratio. With n input rising edges since release (n >= 1) and ratio r, the divided output is high exactly when ((n-1) mod r) < r/2.
- R5: While enabled, `bank_a_out` follows `clk_in` at full input frequency, and `bank_a_out` is low whenever `clk_in` is low.
- R6: A change on `rst_n` reaches `bank_a_out` only at the next falling edge of `clk_in`. During each `clk_in` high phase, `bank_a_out` equals the `rst_n` value seen at the preceding falling edge, so every pass-through pulse lasts a full input high phase.
- R7: A change of `div_sel` while running takes effect immediately, and the divider count is kept, so the formula of R4 continues to hold with the new ratio.
- R8: With `div_sel` and `rst_n` steady, the divided outputs change only at input rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock, divided and passed through |
| rst_n | input | 1 | Active-low control: asynchronous divider clear, falling-edge-synchronised pass-through gate |
| div_sel | input | 2 | Divide ratio select (00: /2, 01: /4, 10: /8, 11: /16) |
| bank_a_out | output | 1 | Gated undivided copy of `clk_in` |
| bank_b_out | output | 2 | Identical copies of the divided clock |

## Verification
The assertions assume two things about the inputs. First, `rst_n` and `div_sel` never change at an input clock edge. Second, `rst_n` is driven low before the first input edge, so the divider starts from a cleared state. The stimulus meets both conditions: it changes the controls only at 3 time units after an input rising edge, in the middle of the high phase, and it drives reset low at time 1. Because the controls change while the clock is high, every reset assertion and release is a real test of the pass-through gate's protection against short pulses. The sweep covers every select value from reset, plus select changes without a reset.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Ratio selected by a select code: 2 << code.
  function automatic int unsigned ratio_of(input int unsigned code);
    return 2 << code;
  endfunction

  // Divider count bit that forms the output for a select code.
  function automatic int unsigned tap_of(input int unsigned code);
    return code;
  endfunction

  // Divider count value loaded by reset (all ones, so the next edge wraps to zero).
  function automatic logic [15:0] clear_value(input int unsigned width);
    return 16'((32'd1 << width) - 32'd1);
  endfunction
endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_in,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count
);
  import clkdiv_pkg::*;

  localparam logic [CNT_W-1:0] CLR = CNT_W'(clear_value(CNT_W));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) count <= CLR;
    else        count <= count + 1'b1;
  end
endmodule

// File: rtl/clkdiv_tap_mux.sv
module clkdiv_tap_mux #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] count,
  input  logic [SEL_W-1:0] div_sel,
  output logic             div_clk
);
  import clkdiv_pkg::*;

  logic [CNT_W-1:0] inv_bits;

  // Inverted taps: the reset count of all ones gives a low output,
  // and the first increment (to zero) gives a high output at every ratio.
  genvar g;
  generate
    for (g = 0; g < CNT_W; g++) begin : g_tap
      assign inv_bits[g] = ~count[tap_of(g)];
    end
  endgenerate

  assign div_clk = inv_bits[div_sel];
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic clk_in,
  input  logic rst_n,
  output logic gate_en,
  output logic gated_clk
);
  logic en_q;

  // Sampled while the clock falls, so the gate only changes during the low phase.
  always_ff @(negedge clk_in) en_q <= rst_n;

  assign gate_en   = en_q;
  assign gated_clk = clk_in & en_q;
endmodule

// File: rtl/clkdiv_dual_bank.sv
module clkdiv_dual_bank #(
  parameter int SEL_W = 2,
  parameter int NUM_B = 2
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  output logic             bank_a_out,
  output logic [NUM_B-1:0] bank_b_out
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] div_count;
  logic             div_clk;
  logic             gate_en;

  clkdiv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .count  (div_count)
  );

  clkdiv_tap_mux #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_mux (
    .count   (div_count),
    .div_sel (div_sel),
    .div_clk (div_clk)
  );

  clkdiv_gate u_gate (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .gate_en   (gate_en),
    .gated_clk (bank_a_out)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_B; c++) begin : g_copy
      assign bank_b_out[c] = div_clk;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_dual_bank_chk.sv
module clkdiv_dual_bank_chk #(
  parameter int SEL_W = 2,
  parameter int NUM_B = 2
) (
  input logic             clk_in,
  input logic             rst_n,
  input logic [SEL_W-1:0] div_sel,
  input logic             bank_a_out,
  input logic [NUM_B-1:0] bank_b_out
);
  logic armed = 1'b0;
  always_ff @(negedge clk_in) armed <= 1'b1;

  // R3: divided bank low whenever reset is low at an edge
  a_r3_async_clear: assert property (@(posedge clk_in)
    !rst_n |-> (bank_b_out == '0));

  // R2: all copies identical
  a_r2_copies_match: assert property (@(posedge clk_in)
    ($countones(bank_b_out) == 0) || ($countones(bank_b_out) == NUM_B));

  // R1: divide by two toggles every edge
  a_r1_div2_toggle: assert property (@(posedge clk_in) disable iff (!rst_n)
    (div_sel == '0 && $past(div_sel) == '0 && $past(rst_n))
      |-> (bank_b_out[0] != $past(bank_b_out[0])));

  // R4: low at release, high after the first edge
  a_r4_low_at_release: assert property (@(posedge clk_in) disable iff (!rst_n)
    (rst_n && !$past(rst_n)) |-> (bank_b_out[0] == 1'b0));
  a_r4_first_rise: assert property (@(posedge clk_in) disable iff (!rst_n)
    (rst_n && !$past(rst_n)) |=> bank_b_out[0]);

  // R5: pass-through never high while the input clock is low
  a_r5_low_with_input: assert property (@(posedge clk_in)
    !bank_a_out);

  // R6: high phase follows the control value seen at the previous falling edge
  a_r6_gate_follows: assert property (@(negedge clk_in)
    armed |-> (bank_a_out == $past(rst_n)));
endmodule

bind clkdiv_dual_bank clkdiv_dual_bank_chk #(.SEL_W(SEL_W), .NUM_B(NUM_B)) u_chk (
  .clk_in     (clk_in),
  .rst_n      (rst_n),
  .div_sel    (div_sel),
  .bank_a_out (bank_a_out),
  .bank_b_out (bank_b_out)
);

// File: tb/clkdiv_dual_bank_test.sv
module clkdiv_dual_bank_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  HALF       = CLK_PERIOD / 2;
  localparam int  WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n_d = 1'b1;
  logic [1:0] sel_d = 2'b00;
  logic       bank_a_out;
  logic [1:0] bank_b_out;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  string tag = "R3";

  int  n = 0;
  logic exp_en = 1'b0;
  bit  en_known = 1'b0;
  time last_pos = 0;
  time last_dist = 0;
  time prev_rise = 0;
  time b_rise = 0;
  time a_rise = 0;

  clkdiv_dual_bank uut (
    .clk_in     (clk),
    .rst_n      (rst_n_d),
    .div_sel    (sel_d),
    .bank_a_out (bank_a_out),
    .bank_b_out (bank_b_out)
  );

  always #HALF clk = ~clk;

  function automatic int ratio(input logic [1:0] s);
    return 2 << s;
  endfunction

  function automatic logic exp_b(input int edges, input logic [1:0] s, input logic rn);
    int r;
    r = ratio(s);
    if (!rn || edges == 0) return 1'b0;
    return ((edges - 1) % r) < (r / 2);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // edge counting model
  always @(posedge clk) begin
    last_pos = $time;
    if (rst_n_d) n = n + 1;
    else n = 0;
  end

  always @(negedge clk) begin
    exp_en = rst_n_d;
    en_known = 1'b1;
  end

  // per-cycle sampling: high phase at +2, low phase at +7
  always @(posedge clk) begin
    #2;
    check(bank_b_out[0] == exp_b(n, sel_d, rst_n_d), tag,
          int'(bank_b_out[0]), int'(exp_b(n, sel_d, rst_n_d)));
    check(bank_b_out[1] == bank_b_out[0], "R2", int'(bank_b_out[1]), int'(bank_b_out[0]));
    if (en_known) check(bank_a_out == exp_en, "R5", int'(bank_a_out), int'(exp_en));
    #5;
    check(bank_a_out == 1'b0, "R5", int'(bank_a_out), 0);
  end

  // R8: divided transitions only at input rising edges or control changes
  always @(bank_b_out[0]) begin
    if ($time > 2 && $time != last_pos && $time != last_dist)
      check(1'b0, "R8", int'($time), int'(last_pos));
  end

  // R1: period and high time with steady controls
  always @(posedge bank_b_out[0]) begin
    if (prev_rise != 0 && prev_rise > last_dist)
      check(($time - prev_rise) == time'(ratio(sel_d) * CLK_PERIOD), "R1",
            int'($time - prev_rise), ratio(sel_d) * CLK_PERIOD);
    prev_rise = $time;
    b_rise = $time;
  end

  always @(negedge bank_b_out[0]) begin
    if (b_rise != 0 && b_rise > last_dist)
      check(($time - b_rise) == time'(ratio(sel_d) * HALF), "R1",
            int'($time - b_rise), ratio(sel_d) * HALF);
  end

  // R6: every pass-through pulse is a full high phase
  always @(posedge bank_a_out) a_rise = $time;
  always @(negedge bank_a_out) begin
    if (a_rise != 0)
      check(($time - a_rise) == time'(HALF), "R6", int'($time - a_rise), HALF);
  end

  task automatic mid_high();
    @(posedge clk);
    #3;
  endtask

  task automatic set_rst(input logic v);
    last_dist = $time;
    rst_n_d = v;
  endtask

  task automatic set_sel(input logic [1:0] v);
    last_dist = $time;
    sel_d = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(WD_CYCLES * CLK_PERIOD);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    #1;
    set_rst(1'b0);
    repeat (4) @(posedge clk);
    #2;
    check(bank_b_out == 2'b00, "R3", int'(bank_b_out), 0);
    check(bank_a_out == 1'b0, "R6", int'(bank_a_out), 0);

    for (int s = 0; s < 4; s++) begin
      tag = "R3";
      mid_high();
      set_sel(2'(s));
      repeat (3) mid_high();
      tag = "R4";
      set_rst(1'b1);
      @(posedge clk);
      #2;
      check(bank_b_out[0] == 1'b1, "R4", int'(bank_b_out[0]), 1);
      tag = "R1";
      repeat (4 * ratio(2'(s)) + 8) @(posedge clk);

      // asynchronous clear in the middle of a high phase
      mid_high();
      tag = "R3";
      set_rst(1'b0);
      #1;
      check(bank_b_out == 2'b00, "R3", int'(bank_b_out), 0);
      check(bank_a_out == 1'b1, "R6", int'(bank_a_out), 1);
      #2;
      check(bank_a_out == 1'b0, "R6", int'(bank_a_out), 0);
      repeat (2) mid_high();
    end

    // select changes without reset
    mid_high();
    set_sel(2'b11);
    set_rst(1'b1);
    tag = "R1";
    repeat (37) @(posedge clk);
    for (int k = 0; k < 6; k++) begin
      mid_high();
      tag = "R7";
      set_sel(2'((k * 3 + 1) % 4));
      repeat (23 + k * 5) @(posedge clk);
    end

    // release in the middle of a high phase: first pass-through pulse full width
    mid_high();
    set_rst(1'b0);
    repeat (3) mid_high();
    set_rst(1'b1);
    #1;
    check(bank_a_out == 1'b0, "R6", int'(bank_a_out), 0);
    repeat (10) @(posedge clk);
    #1;
    finish_run();
  end
endmodule